// File: doc/BRIEF.md
# Dual-Speed Single-Wire Slave Bit Engine

This block is the bit-level slave end of a single-wire, open-drain bus. It watches the line through a synchronizer and pulls the line low through an active-low drive enable. The block recognises bus resets from how long the line stays low and answers each reset with a presence pulse. It turns master-started write slots into received bits. In a read slot it sends a zero by holding the line low, and it sends a one by leaving the line alone.

One timing engine serves both speeds. A clock divider makes a 1 µs tick, and a mode flag selects between the regular and the fast time constants. Logic at the byte level turns the fast mode on through a request input. The length of each reset pulse decides whether fast mode stays on or the block falls back to regular speed. A strobe tells the upper logic that a reset was answered. Any bit that was half received when the reset came is thrown away.

Top module: `owire_bit_slave`

## Requirements
- R1: A low period on the line counts as a bus reset when it lasts at least 480 µs at regular speed, or at least 48 µs in fast mode. Every reset is answered with a presence pulse.
- R2: The presence pulse starts 30 µs (fast: 3 µs) after the line goes high again. It holds the line low for 120 µs (fast: 12 µs). Both times may be late by a few clock cycles of synchronizer and register delay.
- R3: A reset of 480 µs or longer always puts the block back in regular mode. The presence pulse that answers it already uses regular timing.
- R4: In fast mode, a reset shorter than 480 µs leaves the block in fast mode. This covers a reset of 80 µs or less.
- R5: `reset_seen_o` pulses high for one cycle in the first cycle of the presence drive. A zero that was sampled in a low period that then grew into a reset is thrown away, so `rx_valid_o` does not pulse for it.
- R6: A write slot is sampled 30 µs (fast: 3 µs) after the falling edge. If the line is high at that point, the bit is 1 and it is delivered at once. If the line is low, the bit is 0 and it is delivered when the line goes high. Each slot gives exactly one single-cycle `rx_valid_o` pulse, with the bit on `rx_bit_o`.
- R7: A slot whose falling edge comes while `rd_mode_i` is 1 is a read slot. It gives one `tx_ack_o` pulse and no received bit. If `tx_bit_i` is 0, the block drives the line low from the falling edge for 30 µs (fast: 3 µs). If `tx_bit_i` is 1, the block never drives the line.
- R8: A low period longer than the slot window (120 µs regular, 16 µs fast) but shorter than the reset threshold gives no bit, no presence pulse and no drive.
- R9: A one-cycle `fast_req_i` pulse while the bus is idle switches the block into fast mode. `fast_o` is 1 exactly while fast mode is on.
- R10: After reset, `drv_low_o`, `fast_o`, `rx_valid_o`, `tx_ack_o` and `reset_seen_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; `TICK_DIV` cycles make one microsecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw bus line level (1 = released/high) |
| fast_req_i | input | 1 | Request to switch into fast mode, taken while idle |
| rd_mode_i | input | 1 | 1 = the next slot is a read slot (the block transmits) |
| tx_bit_i | input | 1 | Bit sent in the next read slot |
| drv_low_o | output | 1 | 1 = pull the bus line low |
| fast_o | output | 1 | Current speed mode, 1 = fast |
| rx_valid_o | output | 1 | One-cycle strobe for a received write bit |
| rx_bit_o | output | 1 | Received bit value, valid with `rx_valid_o` |
| tx_ack_o | output | 1 | One-cycle strobe when a read slot begins |
| reset_seen_o | output | 1 | One-cycle strobe at the start of a presence pulse |

## Verification
Two things can land on the same rising edge. One is delivering a pending zero bit, and the other is detecting a reset together with choosing the speed for the presence pulse that answers it. The bench sets this up by stretching a write-zero low period past the reset threshold. It also ends a fast-mode low period at 500 µs, so the speed flag drops on the same edge that starts the presence wait. The bench passes these cases only if no received bit comes out, exactly one reset strobe appears, and the drive enable is compared on every clock against a presence window timed from the regular constants.

// File: rtl/owb_pkg.sv
package owb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLOT,
      ST_LOW,
      ST_PD_WAIT,
      ST_PD_DRV,
      ST_SETTLE
   } owb_state_e;

endpackage

// File: rtl/owb_sync.sv
module owb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("owb_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         last_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign line_o = chain_q[STAGES-1];
   assign fall_o = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/owb_timebase.sv
module owb_timebase #(
   parameter int TICK_DIV = 100,
   parameter int US_W     = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart_i,
   output logic [US_W-1:0] us_o
);

   localparam int              DIV_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [US_W-1:0] US_MAX = '1;

   logic tick;

   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("owb_timebase: TICK_DIV must be positive");
      end
      if (TICK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             div_q <= '0;
            else if (restart_i || div_q == DIV_LAST) div_q <= '0;
            else                                     div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DIV_LAST) && !restart_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      us_o <= '0;
      else if (restart_i)              us_o <= '0;
      else if (tick && us_o != US_MAX) us_o <= us_o + 1'b1;
   end

   AST_US_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (us_o == US_MAX && !restart_i) |=> (us_o == US_MAX)); // R1

endmodule

// File: rtl/owb_bit_fsm.sv
module owb_bit_fsm
   import owb_pkg::*;
#(
   parameter int US_W         = 10,
   parameter int RST_REG_US   = 480,
   parameter int RST_FAST_US  = 48,
   parameter int SAMP_REG_US  = 30,
   parameter int SAMP_FAST_US = 3,
   parameter int PDW_REG_US   = 30,
   parameter int PDW_FAST_US  = 3,
   parameter int PDL_REG_US   = 120,
   parameter int PDL_FAST_US  = 12,
   parameter int SLOT_REG_US  = 120,
   parameter int SLOT_FAST_US = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            line_hi_i,
   input  logic            fall_i,
   input  logic [US_W-1:0] us_i,
   input  logic            fast_req_i,
   input  logic            rd_mode_i,
   input  logic            tx_bit_i,
   output logic            restart_o,
   output logic            drv_low_o,
   output logic            fast_o,
   output logic            rx_valid_o,
   output logic            rx_bit_o,
   output logic            tx_ack_o,
   output logic            reset_seen_o
);

   localparam logic [US_W-1:0] RST_R  = US_W'(RST_REG_US);
   localparam logic [US_W-1:0] RST_F  = US_W'(RST_FAST_US);
   localparam logic [US_W-1:0] SAMP_R = US_W'(SAMP_REG_US);
   localparam logic [US_W-1:0] SAMP_F = US_W'(SAMP_FAST_US);
   localparam logic [US_W-1:0] PDW_R  = US_W'(PDW_REG_US);
   localparam logic [US_W-1:0] PDW_F  = US_W'(PDW_FAST_US);
   localparam logic [US_W-1:0] PDL_R  = US_W'(PDL_REG_US);
   localparam logic [US_W-1:0] PDL_F  = US_W'(PDL_FAST_US);
   localparam logic [US_W-1:0] SLOT_R = US_W'(SLOT_REG_US);
   localparam logic [US_W-1:0] SLOT_F = US_W'(SLOT_FAST_US);

   owb_state_e      st_q;
   logic            fast_q;
   logic            is_read_q;
   logic            rd_zero_q;
   logic            pend0_q;
   logic [US_W-1:0] rst_thr, samp_t, pdw_t, pdl_t, slot_t;
   logic            is_rst;

   // speed-dependent time constants
   always_comb begin
      rst_thr = fast_q ? RST_F  : RST_R;
      samp_t  = fast_q ? SAMP_F : SAMP_R;
      pdw_t   = fast_q ? PDW_F  : PDW_R;
      pdl_t   = fast_q ? PDL_F  : PDL_R;
      slot_t  = fast_q ? SLOT_F : SLOT_R;
   end

   assign is_rst = (us_i >= rst_thr);

   assign restart_o = (st_q == ST_IDLE    && fall_i)
                   || (st_q == ST_LOW     && line_hi_i && is_rst)
                   || (st_q == ST_PD_WAIT && us_i == pdw_t);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         fast_q       <= 1'b0;
         is_read_q    <= 1'b0;
         rd_zero_q    <= 1'b0;
         pend0_q      <= 1'b0;
         rx_valid_o   <= 1'b0;
         rx_bit_o     <= 1'b0;
         tx_ack_o     <= 1'b0;
         reset_seen_o <= 1'b0;
      end else begin
         rx_valid_o   <= 1'b0;
         tx_ack_o     <= 1'b0;
         reset_seen_o <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (fast_req_i) fast_q <= 1'b1;
               if (fall_i) begin
                  st_q      <= ST_SLOT;
                  is_read_q <= rd_mode_i;
                  rd_zero_q <= rd_mode_i & ~tx_bit_i;
                  tx_ack_o  <= rd_mode_i;
                  pend0_q   <= 1'b0;
               end
            end
            ST_SLOT: begin
               if (us_i == samp_t) begin
                  st_q      <= ST_LOW;
                  rd_zero_q <= 1'b0;
                  if (!is_read_q) begin
                     pend0_q <= ~line_hi_i;
                     if (line_hi_i) begin
                        rx_valid_o <= 1'b1;
                        rx_bit_o   <= 1'b1;
                     end
                  end
               end
            end
            ST_LOW: begin
               if (line_hi_i) begin
                  pend0_q <= 1'b0;
                  if (is_rst) begin
                     st_q <= ST_PD_WAIT;
                     if (us_i >= RST_R) fast_q <= 1'b0;
                  end else begin
                     st_q <= ST_IDLE;
                     if (pend0_q && us_i <= slot_t) begin
                        rx_valid_o <= 1'b1;
                        rx_bit_o   <= 1'b0;
                     end
                  end
               end
            end
            ST_PD_WAIT: begin
               if (us_i == pdw_t) begin
                  st_q         <= ST_PD_DRV;
                  reset_seen_o <= 1'b1;
               end
            end
            ST_PD_DRV: begin
               if (us_i == pdl_t) st_q <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (line_hi_i) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign drv_low_o = (st_q == ST_PD_DRV) || (st_q == ST_SLOT && rd_zero_q);
   assign fast_o    = fast_q;

   AST_PRESENCE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      reset_seen_o |-> drv_low_o); // R5
   AST_ONE_BIT_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o); // R6
   AST_FAST_BY_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fast_q) |-> $past(fast_req_i)); // R9
   AST_LONG_RESET_REGULAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fast_q) |-> ($past(us_i) >= RST_R)); // R3
   AST_READ_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ack_o |-> !rx_valid_o); // R7

endmodule

// File: rtl/owire_bit_slave.sv
module owire_bit_slave #(
   parameter int TICK_DIV     = 100,
   parameter int SYNC_STAGES  = 2,
   parameter int US_W         = 10,
   parameter int RST_REG_US   = 480,
   parameter int RST_FAST_US  = 48,
   parameter int SAMP_REG_US  = 30,
   parameter int SAMP_FAST_US = 3,
   parameter int PDW_REG_US   = 30,
   parameter int PDW_FAST_US  = 3,
   parameter int PDL_REG_US   = 120,
   parameter int PDL_FAST_US  = 12,
   parameter int SLOT_REG_US  = 120,
   parameter int SLOT_FAST_US = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic fast_req_i,
   input  logic rd_mode_i,
   input  logic tx_bit_i,
   output logic drv_low_o,
   output logic fast_o,
   output logic rx_valid_o,
   output logic rx_bit_o,
   output logic tx_ack_o,
   output logic reset_seen_o
);

   generate
      if (RST_REG_US >= (1 << US_W) - 1) begin : g_bad_width
         $error("owire_bit_slave: US_W too narrow for the reset threshold");
      end
      if (RST_FAST_US >= RST_REG_US) begin : g_bad_rst
         $error("owire_bit_slave: fast reset threshold must be below regular");
      end
      if (SAMP_REG_US >= SLOT_REG_US || SAMP_FAST_US >= SLOT_FAST_US) begin : g_bad_samp
         $error("owire_bit_slave: sample point must fall inside the slot window");
      end
      if (SLOT_REG_US >= RST_REG_US || SLOT_FAST_US >= RST_FAST_US) begin : g_bad_slot
         $error("owire_bit_slave: slot window must end before the reset threshold");
      end
   endgenerate

   logic            line_hi;
   logic            fall;
   logic            restart;
   logic [US_W-1:0] us;

   owb_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_i),
      .line_o (line_hi),
      .fall_o (fall)
   );

   owb_timebase #(.TICK_DIV(TICK_DIV), .US_W(US_W)) u_time (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .us_o      (us)
   );

   owb_bit_fsm #(
      .US_W        (US_W),
      .RST_REG_US  (RST_REG_US),
      .RST_FAST_US (RST_FAST_US),
      .SAMP_REG_US (SAMP_REG_US),
      .SAMP_FAST_US(SAMP_FAST_US),
      .PDW_REG_US  (PDW_REG_US),
      .PDW_FAST_US (PDW_FAST_US),
      .PDL_REG_US  (PDL_REG_US),
      .PDL_FAST_US (PDL_FAST_US),
      .SLOT_REG_US (SLOT_REG_US),
      .SLOT_FAST_US(SLOT_FAST_US)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_hi_i    (line_hi),
      .fall_i       (fall),
      .us_i         (us),
      .fast_req_i   (fast_req_i),
      .rd_mode_i    (rd_mode_i),
      .tx_bit_i     (tx_bit_i),
      .restart_o    (restart),
      .drv_low_o    (drv_low_o),
      .fast_o       (fast_o),
      .rx_valid_o   (rx_valid_o),
      .rx_bit_o     (rx_bit_o),
      .tx_ack_o     (tx_ack_o),
      .reset_seen_o (reset_seen_o)
   );

endmodule

// File: tb/owire_bit_slave_tb.sv
module owire_bit_slave_tb;

   localparam int TDIV = 4;
   localparam int RR = 480, RF = 48;
   localparam int SR = 30,  SF = 3;
   localparam int WR = 30,  WF = 3;
   localparam int LR = 120, LF = 12;
   localparam int XR = 120, XF = 16;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, m_low, fast_req, rd_mode, tx_bit, line;
   logic drv_low, fast_o, rx_valid, rx_bit, tx_ack, reset_seen;

   assign line = ~(m_low | drv_low);

   owire_bit_slave #(.TICK_DIV(TDIV)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_i       (line),
      .fast_req_i   (fast_req),
      .rd_mode_i    (rd_mode),
      .tx_bit_i     (tx_bit),
      .drv_low_o    (drv_low),
      .fast_o       (fast_o),
      .rx_valid_o   (rx_valid),
      .rx_bit_o     (rx_bit),
      .tx_ack_o     (tx_ack),
      .reset_seen_o (reset_seen)
   );

   int    cyc = 0;
   int    n_chk = 0, n_fail = 0;
   int    win_s = -1000, win_e = -1000, mode_hold = 0;
   int    got_rx = 0, got_rst = 0, got_ack = 0, exp_rst = 0, exp_ack = 0;
   bit    exp_fast = 1'b0, chk_on = 1'b0, done = 1'b0, exp_b;
   bit    q_rx[$];
   string cur_tag = "R10";

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   // behavioural reference compared on every clock
   always @(negedge clk) begin
      if (chk_on) begin
         if (cyc >= win_s + 6 && cyc <= win_e - 1)
            chk(drv_low == 1'b1, cur_tag, "drive inside window", drv_low, 1);
         else if (cyc < win_s || cyc > win_e + 7)
            chk(drv_low == 1'b0, cur_tag, "drive outside window", drv_low, 0);
         if (cyc > mode_hold)
            chk(fast_o == exp_fast, cur_tag, "speed mode", fast_o, exp_fast);
         if (rx_valid) begin
            got_rx++;
            if (q_rx.size() == 0) chk(1'b0, cur_tag, "unexpected rx bit", rx_bit, -1);
            else begin
               exp_b = q_rx.pop_front();
               chk(rx_bit == exp_b, cur_tag, "rx bit value", rx_bit, exp_b);
            end
         end
         if (reset_seen) got_rst++;
         if (tx_ack)     got_ack++;
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // master holds the line low for len_us; model derives the expected outcome
   task automatic master_low(input int len_us);
      int thr, sm, smax, rel, w, l, waitc;
      thr  = exp_fast ? RF : RR;
      sm   = exp_fast ? SF : SR;
      smax = exp_fast ? XF : XR;
      @(posedge clk); #1 m_low = 1'b1;
      repeat (len_us * TDIV) @(posedge clk);
      #1 m_low = 1'b0;
      rel = cyc;
      if (len_us >= thr) begin
         if (len_us >= RR) begin
            exp_fast  = 1'b0;
            mode_hold = rel + 10;
         end
         exp_rst++;
         w = exp_fast ? WF : WR;
         l = exp_fast ? LF : LR;
         win_s = rel + w * TDIV;
         win_e = win_s + l * TDIV;
         waitc = (w + l) * TDIV + 40;
      end else begin
         if (len_us < sm)         q_rx.push_back(1'b1);
         else if (len_us <= smax) q_rx.push_back(1'b0);
         waitc = (sm + 10) * TDIV;
      end
      repeat (waitc) @(posedge clk);
   endtask

   task automatic write_bit(input bit b);
      if (exp_fast) master_low(b ? 1 : 8);
      else          master_low(b ? 5 : 60);
   endtask

   task automatic read_slot(input bit b);
      int sm, m;
      sm = exp_fast ? SF : SR;
      @(posedge clk); #1 rd_mode = 1'b1; tx_bit = b;
      @(posedge clk); #1 m_low = 1'b1;
      m = cyc;
      exp_ack++;
      if (!b) begin
         win_s = m;
         win_e = m + sm * TDIV;
      end
      repeat (TDIV) @(posedge clk);
      #1 m_low = 1'b0;
      repeat ((sm + 10) * TDIV) @(posedge clk);
      #1 rd_mode = 1'b0; tx_bit = 1'b1;
   endtask

   task automatic request_fast();
      @(posedge clk); #1 fast_req = 1'b1;
      exp_fast  = 1'b1;
      mode_hold = cyc + 4;
      @(posedge clk); #1 fast_req = 1'b0;
      repeat (8) @(posedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete");
         finish_run();
      end
   end

   initial begin
      int rx_before, rst_before;
      rst_n = 1'b0; m_low = 1'b0; fast_req = 1'b0; rd_mode = 1'b0; tx_bit = 1'b1;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(drv_low == 1'b0,    "R10", "drv_low after reset", drv_low, 0);
      chk(fast_o == 1'b0,     "R10", "fast after reset", fast_o, 0);
      chk(rx_valid == 1'b0,   "R10", "rx_valid after reset", rx_valid, 0);
      chk(tx_ack == 1'b0,     "R10", "tx_ack after reset", tx_ack, 0);
      chk(reset_seen == 1'b0, "R10", "reset_seen after reset", reset_seen, 0);
      chk_on = 1'b1;

      // R1 / R2: regular reset and presence timing
      cur_tag = "R2";
      master_low(500);
      chk(got_rst == 1, "R1", "reset strobes after regular reset", got_rst, 1);

      // R6: regular write slots
      cur_tag = "R6";
      write_bit(1'b1); write_bit(1'b0); write_bit(1'b1); write_bit(1'b1); write_bit(1'b0);
      chk(got_rx == 5, "R6", "regular bits received", got_rx, 5);

      // R7: regular read slots
      cur_tag = "R7";
      read_slot(1'b0); read_slot(1'b1); read_slot(1'b0);
      chk(got_ack == 3, "R7", "read slot acks", got_ack, 3);
      chk(got_rx == 5,  "R7", "no rx from read slots", got_rx, 5);

      // R8: too long for a slot, too short for a reset
      cur_tag = "R8";
      rx_before = got_rx; rst_before = got_rst;
      master_low(200);
      chk(got_rx == rx_before,   "R8", "no bit from ignored low", got_rx, rx_before);
      chk(got_rst == rst_before, "R8", "no reset from ignored low", got_rst, rst_before);

      // R5: a sampled zero that grows into a reset is discarded
      cur_tag = "R5";
      rx_before = got_rx;
      master_low(490);
      chk(got_rx == rx_before, "R5", "pending zero discarded", got_rx, rx_before);
      chk(got_rst == 2,        "R5", "reset strobe count", got_rst, 2);

      // R9: enter fast mode
      cur_tag = "R9";
      request_fast();
      chk(fast_o == 1'b1, "R9", "fast after request", fast_o, 1);

      // R6 / R7 in fast mode
      cur_tag = "R6";
      write_bit(1'b0); write_bit(1'b1); write_bit(1'b1);
      cur_tag = "R7";
      read_slot(1'b0);

      // R8 in fast mode
      cur_tag = "R8";
      rx_before = got_rx;
      master_low(30);
      chk(got_rx == rx_before, "R8", "fast ignored low gives no bit", got_rx, rx_before);

      // R4: fast resets below the regular threshold keep fast mode
      cur_tag = "R4";
      master_low(60);
      chk(fast_o == 1'b1, "R4", "fast kept after 60 us reset", fast_o, 1);
      master_low(300);
      chk(fast_o == 1'b1, "R4", "fast kept after 300 us reset", fast_o, 1);

      // R3: long reset drops to regular, presence in regular timing
      cur_tag = "R3";
      master_low(500);
      chk(fast_o == 1'b0, "R3", "regular after long reset", fast_o, 0);

      cur_tag = "R6";
      write_bit(1'b1);

      chk(q_rx.size() == 0, "R6", "expected bits left undelivered", q_rx.size(), 0);
      chk(got_rst == exp_rst, "R1", "total reset strobes", got_rst, exp_rst);
      chk(got_ack == exp_ack, "R7", "total read acks", got_ack, exp_ack);
      finish_run();
   end

endmodule